// File: doc/BRIEF.md
# Linked-List Command Fetch Walker

This block walks a chain of command packets held in system memory and forwards their payload words to a downstream command framer. A walk begins when `start` is pulsed with the byte address of the first node. Each node begins with a header word that holds the payload word count and a 24-bit pointer to the next node. The payload words sit directly after the header. The walker reads each header, rewrites it with a visit marker, streams the payload over a valid/ready interface, and then follows the pointer.

A walk stops on a pointer whose bit 23 is set. The all-ones end code has this bit set, and so does any header the walker has already marked. Because of this, a chain that loops back on itself stops after at most one repeated node. A cleanup pass then starts again from the first node and clears the marker in every node whose successor was followed. A one-cycle `done` pulse ends the operation and carries the final cycle-cost estimate for the chain.

The memory port is a plain word-addressed read/write port. Read data returns exactly one cycle after the read strobe, and a write completes in the cycle it is issued.

Top module: `lldma_walker`

## Requirements
- R1: A header word is decoded as payload count = bits 31:24 and next-node pointer = bits 23:0.
- R2: A node pointer addresses memory through bits 20:2 only (word address = (pointer mod 2 MB) / 4). Pointer bits 23:21 do not change the address. Payload word k (1-based) is read from the header word address + k, and the payload words leave on `out_data` in that order.
- R3: A node whose count is zero puts no word on the output stream.
- R4: The walk ends after a node whose next pointer has bit 23 set; this covers the end code 0xFFFFFF. A start pointer equal to 0xFFFFFF visits no node.
- R5: Each visited header is written back with bit 23 set. The write happens in the cycle right after that header's read, to the same address, and before the node's first payload read.
- R6: When a next pointer leads back to an already visited node, that node is visited again: its count and cost are taken once more and its payload is sent again. The walk then ends.
- R7: After the walk, a cleanup pass starts from the start pointer and follows the stored pointers. It clears bit 23 in as many headers as there were pointers followed during the walk, so every header changed by the walk returns to its original value.
- R8: `cost` adds 10 for each visited node, plus 5 + count for each visited node whose count is non-zero. It restarts from 0 at each start.
- R9: `busy` is high from the cycle after an accepted start until the `done` pulse. `done` is high for exactly one cycle, after the cleanup pass, and `cost` is final in that cycle.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R11: A `start` pulse during a walk has no effect on the stream, the cost or memory.
- R12: After reset, `busy`, `done`, `out_valid`, `mem_rd` and `mem_wr` are low, and no memory access occurs while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken when idle) |
| start_addr | input | PTR_W | Byte pointer to the first node |
| busy | output | 1 | Walk or cleanup in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| cost | output | COST_W | Accumulated cycle-cost estimate |
| mem_rd | output | 1 | Memory read strobe, data one cycle later |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | SPACE_W-2 | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| out_valid | output | 1 | Payload word available |
| out_ready | input | 1 | Framer accepts the word |
| out_data | output | DATA_W | Payload word |

## Verification
The bench uses the default parameters: 32-bit words, 24-bit pointers, a 21-bit byte space and a 32-bit cost. Because the bench memory decodes only the low ten word-address bits, nodes sit in the first 4 KB. Pointers with bits 23:21 set still reach those nodes, which exercises the address masking. With an 8-bit count field, the direct loop A→B→A, a start at the end code and a chain ending on a pre-marked pointer can each be built in a few words, so the marker, repeat and cleanup paths can all be checked against the restored memory image.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_HRD, S_HMARK, S_PRD, S_PCAP, S_POUT, S_STEP, S_CRD, S_CWR, S_DONE
  } walk_state_t;

  localparam int unsigned NODE_COST    = 10;
  localparam int unsigned PAYLOAD_COST = 5;
endpackage

// File: rtl/lldma_hdr_split.sv
module lldma_hdr_split #(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 24
) (
  input  logic [DATA_W-1:0]       word,
  output logic [DATA_W-PTR_W-1:0] cnt,
  output logic [PTR_W-1:0]        nxt,
  output logic                    stop
);
  // R1: count in the top byte, pointer below it
  always_comb begin
    cnt  = word[DATA_W-1:PTR_W];
    nxt  = word[PTR_W-1:0];
    stop = word[PTR_W-1];
  end
endmodule

// File: rtl/lldma_cost_acc.sv
module lldma_cost_acc
  import lldma_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int COST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add,
  input  logic [LEN_W-1:0]  len,
  output logic [COST_W-1:0] cost
);
  logic [COST_W-1:0] inc, cost_d, cost_q;

  // R8: per-node charge
  always_comb begin
    inc = COST_W'(NODE_COST);
    if (len != '0) inc = inc + COST_W'(PAYLOAD_COST) + COST_W'(len);
    cost_d = cost_q;
    if (clr)      cost_d = '0;
    else if (add) cost_d = cost_q + inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cost_q <= '0;
    else if (clr || add)  cost_q <= cost_d;
  end

  assign cost = cost_q;
endmodule

// File: rtl/lldma_walker.sv
module lldma_walker
  import lldma_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PTR_W   = 24,
  parameter int SPACE_W = 21,
  parameter int NODE_CW = 16,
  parameter int COST_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [PTR_W-1:0]     start_addr,
  output logic                 busy,
  output logic                 done,
  output logic [COST_W-1:0]    cost,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [SPACE_W-3:0]   mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DATA_W-1:0]    out_data
);
  localparam int LEN_W  = DATA_W - PTR_W;
  localparam int MEM_AW = SPACE_W - 2;
  localparam logic [PTR_W-1:0]  END_PTR   = {PTR_W{1'b1}};
  localparam logic [DATA_W-1:0] MARK_MASK = DATA_W'(1) << (PTR_W - 1);

  walk_state_t          state_q, state_d;
  logic [PTR_W-1:0]     start_q, start_d, cur_q, cur_d, nxt_q, nxt_d, cl_q, cl_d;
  logic [LEN_W-1:0]     len_q, len_d, idx_q, idx_d;
  logic [NODE_CW-1:0]   nodes_q, nodes_d, left_q, left_d;
  logic [DATA_W-1:0]    dout_q, dout_d;
  logic                 dout_en;
  logic [LEN_W-1:0]     hdr_cnt;
  logic [PTR_W-1:0]     hdr_nxt;
  logic                 hdr_stop;
  logic                 cost_clr, cost_add;

  function automatic logic [MEM_AW-1:0] waddr(input logic [PTR_W-1:0] p);
    return p[SPACE_W-1:2]; // R2: only bits 20:2 reach memory
  endfunction

  lldma_hdr_split #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_split (
    .word(mem_rdata), .cnt(hdr_cnt), .nxt(hdr_nxt), .stop(hdr_stop)
  );

  lldma_cost_acc #(.LEN_W(LEN_W), .COST_W(COST_W)) u_cost (
    .clk(clk), .rst_n(rst_n), .clr(cost_clr), .add(cost_add), .len(hdr_cnt), .cost(cost)
  );

  // Next-state and memory-port logic
  always_comb begin
    state_d   = state_q;
    start_d   = start_q;
    cur_d     = cur_q;
    nxt_d     = nxt_q;
    cl_d      = cl_q;
    len_d     = len_q;
    idx_d     = idx_q;
    nodes_d   = nodes_q;
    left_d    = left_q;
    dout_d    = dout_q;
    dout_en   = 1'b0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = waddr(cur_q);
    mem_wdata = mem_rdata | MARK_MASK;
    cost_clr  = 1'b0;
    cost_add  = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        start_d  = start_addr;
        cur_d    = start_addr;
        nodes_d  = '0;
        cost_clr = 1'b1;
        if (start_addr == END_PTR) begin  // R4: nothing to visit
          cl_d    = start_addr;
          left_d  = '0;
          state_d = S_CRD;
        end else begin
          state_d = S_HRD;
        end
      end
      S_HRD: begin
        mem_rd  = 1'b1;
        state_d = S_HMARK;
      end
      S_HMARK: begin                      // R5: write back with marker
        mem_wr   = 1'b1;
        len_d    = hdr_cnt;
        nxt_d    = hdr_nxt;
        cost_add = 1'b1;
        idx_d    = LEN_W'(1);
        state_d  = (hdr_cnt != '0) ? S_PRD : S_STEP;
      end
      S_PRD: begin
        mem_rd   = 1'b1;
        mem_addr = waddr(cur_q) + MEM_AW'(idx_q);
        state_d  = S_PCAP;
      end
      S_PCAP: begin
        dout_en = 1'b1;
        dout_d  = mem_rdata;
        state_d = S_POUT;
      end
      S_POUT: if (out_ready) begin
        if (idx_q == len_q) state_d = S_STEP;
        else begin
          idx_d   = idx_q + LEN_W'(1);
          state_d = S_PRD;
        end
      end
      S_STEP: begin
        if (nxt_q[PTR_W-1]) begin         // R4/R6: marked or end pointer
          cl_d    = start_q;
          left_d  = nodes_q;
          state_d = S_CRD;
        end else begin
          nodes_d = nodes_q + NODE_CW'(1);
          cur_d   = nxt_q;
          state_d = S_HRD;
        end
      end
      S_CRD: begin
        mem_addr = waddr(cl_q);
        if (left_q == '0) state_d = S_DONE;
        else begin
          mem_rd  = 1'b1;
          state_d = S_CWR;
        end
      end
      S_CWR: begin                        // R7: strip the marker
        mem_addr  = waddr(cl_q);
        mem_wr    = 1'b1;
        mem_wdata = mem_rdata & ~MARK_MASK;
        cl_d      = hdr_nxt;
        left_d    = left_q - NODE_CW'(1);
        state_d   = S_CRD;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      start_q <= '0;
      cur_q   <= '0;
      nxt_q   <= '0;
      cl_q    <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      nodes_q <= '0;
      left_q  <= '0;
      dout_q  <= '0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      cur_q   <= cur_d;
      nxt_q   <= nxt_d;
      cl_q    <= cl_d;
      len_q   <= len_d;
      idx_q   <= idx_d;
      nodes_q <= nodes_d;
      left_q  <= left_d;
      if (dout_en) dout_q <= dout_d;
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_DONE);
  assign out_valid = (state_q == S_POUT);
  assign out_data  = dout_q;
endmodule

// File: rtl/lldma_walker_chk.sv
module lldma_walker_chk #(
  parameter int DATA_W = 32,
  parameter int MEM_AW = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  // R10: stream holds while stalled
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5/R7: every write is the second half of a read-modify-write
  p_rmw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(mem_rd) && ($past(mem_addr) == mem_addr)));

  p_rw_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R9: done is a single pulse that returns the block to idle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R12: quiet while idle
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !mem_rd && !mem_wr));
endmodule

bind lldma_walker lldma_walker_chk #(.DATA_W(DATA_W), .MEM_AW(SPACE_W-2)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/test_lldma_walker.sv
`timescale 1ns/1ps
module test_lldma_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic        busy, done, mem_rd, mem_wr, out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] cost, mem_wdata, out_data;
  logic [31:0] mem_rdata = '0;
  logic [18:0] mem_addr;

  int checks = 0, fails = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] got [0:63];
  int got_n = 0, marks = 0, clears = 0, rd_n = 0, cyc = 0;
  int rd1_cyc = -1, rd2_cyc = -1, wr1_cyc = -1;
  logic [18:0] rd1_addr = '0, wr1_addr = '0;
  bit stall_mode = 0;
  logic [31:0] cost_seen;

  always #2.5 clk = ~clk;

  lldma_walker i_lldma_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .busy(busy), .done(done), .cost(cost),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
  end

  // monitors
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (out_valid && out_ready) begin
      got[got_n[5:0]] <= out_data;
      got_n <= got_n + 1;
    end
    if (mem_wr) begin
      if (mem_wdata[23]) marks <= marks + 1;
      else clears <= clears + 1;
      if (wr1_cyc < 0) begin wr1_cyc <= cyc; wr1_addr <= mem_addr; end
    end
    if (mem_rd) begin
      rd_n <= rd_n + 1;
      if (rd_n == 0) begin rd1_cyc <= cyc; rd1_addr <= mem_addr; end
      if (rd_n == 1) rd2_cyc <= cyc;
    end
  end

  always @(negedge clk) out_ready <= stall_mode ? ~out_ready : 1'b1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
  endtask

  // start a walk and wait for done; optional second start while busy
  task automatic run_walk(input logic [23:0] a, input bit restart);
    int t;
    @(negedge clk);
    got_n = 0; marks = 0; clears = 0; rd_n = 0;
    rd1_cyc = -1; rd2_cyc = -1; wr1_cyc = -1;
    start = 1'b1; start_addr = a;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    t = 0;
    while (!done && t < 4000) begin
      if (restart && t == 6) begin start = 1'b1; start_addr = 24'h000300; end  // R11
      else start = 1'b0;
      @(negedge clk);
      t++;
    end
    start = 1'b0;
    chk(done == 1'b1, "R9 done reached", done, 1);
    cost_seen = cost;
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9 done one cycle", {done, busy}, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !out_valid && !mem_rd && !mem_wr, "R12 reset state",
        {busy, done, out_valid, mem_rd, mem_wr}, 0);
    chk(cost == 0, "R12 cost reset", cost, 0);
  endtask

  task automatic load_chain();
    clear_mem();
    mem[10'h040] = {8'd2, 24'h000200};           // A
    mem[10'h041] = 32'hA1; mem[10'h042] = 32'hA2;
    mem[10'h080] = {8'd0, 24'h000300};           // B, no payload
    mem[10'h0C0] = {8'd3, 24'hFFFFFF};           // C
    mem[10'h0C1] = 32'hC1; mem[10'h0C2] = 32'hC2; mem[10'h0C3] = 32'hC3;
  endtask

  task automatic t_chain(input bit stall, input bit restart);
    load_chain();
    stall_mode = stall;
    run_walk(24'h000100, restart);
    stall_mode = 0;
    chk(got_n == 5, "R3 word count chain", got_n, 5);
    chk(got[0] == 32'hA1 && got[1] == 32'hA2, "R2 payload order A", got[1], 32'hA2);
    chk(got[2] == 32'hC1 && got[4] == 32'hC3, "R2 payload order C", got[4], 32'hC3);
    chk(cost_seen == 45, "R8 chain cost", cost_seen, 45);
    chk(marks == 3, "R5 marker writes", marks, 3);
    chk(clears == 2, "R7 cleanup writes", clears, 2);
    chk(mem[10'h040] == {8'd2, 24'h000200} && mem[10'h080] == {8'd0, 24'h000300},
        "R7 headers restored", mem[10'h080], {8'd0, 24'h000300});
    chk(mem[10'h0C0] == {8'd3, 24'hFFFFFF}, "R4 end header intact", mem[10'h0C0], {8'd3, 24'hFFFFFF});
    if (restart)
      chk(got_n == 5 && cost_seen == 45, "R11 start ignored while busy", cost_seen, 45);
  endtask

  task automatic t_mark_order();
    load_chain();
    run_walk(24'h000100, 0);
    chk(rd1_addr == 19'h040 && wr1_addr == 19'h040, "R5 mark write same address", wr1_addr, 19'h040);
    chk(wr1_cyc == rd1_cyc + 1, "R5 mark write next cycle", wr1_cyc, rd1_cyc + 1);
    chk(rd2_cyc > wr1_cyc, "R5 mark before payload read", rd2_cyc, wr1_cyc + 1);
  endtask

  task automatic t_loop();
    clear_mem();
    mem[10'h100] = {8'd1, 24'h000500};
    mem[10'h101] = 32'h5A1;
    mem[10'h140] = {8'd2, 24'h000400};
    mem[10'h141] = 32'h5B1; mem[10'h142] = 32'h5B2;
    run_walk(24'h000400, 0);
    chk(got_n == 4, "R6 loop word count", got_n, 4);
    chk(got[0] == 32'h5A1 && got[3] == 32'h5A1, "R6 repeat payload", got[3], 32'h5A1);
    chk(cost_seen == 49, "R6 R8 loop cost", cost_seen, 49);
    chk(mem[10'h100] == {8'd1, 24'h000500} && mem[10'h140] == {8'd2, 24'h000400},
        "R7 loop headers restored", mem[10'h100], {8'd1, 24'h000500});
  endtask

  task automatic t_end_start();
    clear_mem();
    run_walk(24'hFFFFFF, 0);
    chk(got_n == 0 && marks == 0 && rd_n == 0, "R4 end start visits nothing", rd_n, 0);
    chk(cost_seen == 0, "R8 empty cost", cost_seen, 0);
  endtask

  task automatic t_premarked();
    clear_mem();
    mem[10'h240] = {8'd1, 24'h800800};
    mem[10'h241] = 32'h77;
    run_walk(24'h000900, 0);
    chk(got_n == 1 && got[0] == 32'h77, "R4 premarked stops", got_n, 1);
    chk(cost_seen == 16, "R8 single node cost", cost_seen, 16);
    chk(clears == 0 && mem[10'h240] == {8'd1, 24'h800800}, "R7 no cleanup", clears, 0);
  endtask

  task automatic t_masking();
    clear_mem();
    mem[10'h180] = {8'd1, 24'h600700};
    mem[10'h181] = 32'h99;
    mem[10'h1C0] = {8'd0, 24'hFFFFFF};
    run_walk(24'h400600, 0);
    chk(got_n == 1 && got[0] == 32'h99, "R2 masked start", got[0], 32'h99);
    chk(cost_seen == 26, "R1 R8 masked cost", cost_seen, 26);
    chk(mem[10'h180] == {8'd1, 24'h600700}, "R7 masked restore", mem[10'h180], {8'd1, 24'h600700});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chain(0, 0);
    t_chain(1, 1);
    t_mark_order();
    t_loop();
    t_end_start();
    t_premarked();
    t_masking();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule